// File: doc/BRIEF.md
# Modulus Event Timer

The block is a programmable counter of configurable width. It holds a modulus register, a current count register and a control word. While the run flag is set, the counter advances on the selected event source. The sources are: every core clock cycle, a single-bit internal pulse, a two-lane pulse input that can add two in one cycle, or the synchronized rising edges of one of several external pins. When an update brings the count up to or past the modulus, the count folds back by the modulus and a one-cycle interrupt pulse goes out. Software never has to clear that pulse.

Software loads the modulus, presets the count or changes the control word through a simple write port. It reads any register through a separate combinational read port. A preset that puts the count at or beyond the modulus produces no interrupt. The count then runs on to the top of its range, rolls over through zero silently, and then resumes normal modulus behaviour.

Top module: `evt_timer`

## Requirements
- R1: The count changes only through a count write or while run (control bit 0) is 1; with run at 0 and no count write, the count holds its value.
- R2: The event select (control bits 4:1) picks the increment for each cycle. Code 0 adds 1 every cycle. Code 1 adds tick_i. Code 2 adds the number of bits set in dbl_i (0, 1 or 2). Code 3+k counts pin k for k below NPIN. Every other code adds nothing.
- R3: Pin k counts only low-to-high transitions, after a two-stage synchronizer. A rise first sampled high at clock edge n adds one at edge n+2. A held level or a falling edge adds nothing.
- R4: If the count is below the modulus and count+increment is at least the modulus, the new count is count+increment-modulus (0, or 1 when a +2 step overshoots by one).
- R5: irq_o is 1 for exactly the cycle that follows each R4 wrap update and is 0 otherwise; it needs no acknowledge.
- R6: A modulus write leaves the count unchanged. The cycle of the write still counts against the old modulus, and the new modulus applies from the next cycle.
- R7: A count write takes priority over any count update in the same cycle and suppresses that cycle's interrupt. A count written equal to the modulus raises no interrupt, and with run set the count moves on to modulus+1 or modulus+2.
- R8: A count at or above the modulus keeps incrementing and rolls over at 2^W to 0 or 1 with no interrupt. Normal modulus comparison applies again after that.
- R9: With a modulus of zero no interrupt is ever raised; the count free-runs modulo 2^W.
- R10: The byte offsets are 0x0 modulus, 0x4 count and 0x8 control. A write to any other offset changes nothing. A read of the control word returns run in bit 0 and select in bits 4:1, with zeros above. A read of any other offset returns zero.
- R11: Reset clears modulus, count, run, select and irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write byte offset |
| wr_data | input | W | Write data |
| rd_addr | input | 4 | Read byte offset |
| rd_data | output | W | Read data for rd_addr |
| tick_i | input | 1 | Internal single-step event |
| dbl_i | input | 2 | Two-lane event, each set bit adds one |
| pin_i | input | NPIN | Asynchronous external pins |
| irq_o | output | 1 | One-cycle wrap interrupt pulse |

## Verification
The bench builds the block with W=8 and NPIN=2. With the 8-bit width, the silent roll-over at the top of the count range (R8) and free-running with a zero modulus (R9) take only a few hundred cycles. The two pins are enough to show that the select code chooses a pin and that the other pin is ignored. A behavioural model in the bench tracks modulus, count, control and the pin history. The bench compares irq_o and a randomly addressed read on every cycle while the event inputs change at random.

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int W    = 32,
  parameter int NPIN = 4,
  parameter int SELW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [3:0]      wr_addr,
  input  logic [W-1:0]    wr_data,
  input  logic [3:0]      rd_addr,
  output logic [W-1:0]    rd_data,
  input  logic            tick_i,
  input  logic [1:0]      dbl_i,
  input  logic [NPIN-1:0] pin_i,
  output logic            irq_o
);
  localparam int PIN_BASE = 3;
  localparam logic [3:0] OFS_MOD = 4'h0;
  localparam logic [3:0] OFS_VAL = 4'h4;
  localparam logic [3:0] OFS_CTL = 4'h8;

  logic [W-1:0]    mod_q, val_q;
  logic            run_q;
  logic [SELW-1:0] sel_q;
  logic [NPIN-1:0] sync1_q, sync2_q, prev_q;
  logic [NPIN-1:0] pin_rise;
  logic [1:0]      inc;
  logic [W:0]      sum, folded;
  logic            hit;
  logic [W-1:0]    next_cnt;

  wire wr_mod = wr_en && (wr_addr == OFS_MOD);
  wire wr_val = wr_en && (wr_addr == OFS_VAL);
  wire wr_ctl = wr_en && (wr_addr == OFS_CTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign pin_rise = sync2_q & ~prev_q;

  always_comb begin
    inc = 2'd0;
    if (run_q) begin
      if (sel_q == SELW'(0))      inc = 2'd1;
      else if (sel_q == SELW'(1)) inc = {1'b0, tick_i};
      else if (sel_q == SELW'(2)) inc = {1'b0, dbl_i[0]} + {1'b0, dbl_i[1]};
      else begin
        for (int i = 0; i < NPIN; i++)
          if (sel_q == SELW'(PIN_BASE + i)) inc = {1'b0, pin_rise[i]};
      end
    end
  end

  assign sum      = {1'b0, val_q} + {{(W-1){1'b0}}, inc};
  assign folded   = sum - {1'b0, mod_q};
  assign hit      = (val_q < mod_q) && (inc != 2'd0) && (sum >= {1'b0, mod_q});
  assign next_cnt = hit ? folded[W-1:0] : sum[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q <= '0;
      val_q <= '0;
      run_q <= 1'b0;
      sel_q <= '0;
      irq_o <= 1'b0;
    end else begin
      if (wr_mod) mod_q <= wr_data;
      if (wr_ctl) begin
        run_q <= wr_data[0];
        sel_q <= wr_data[SELW:1];
      end
      val_q <= wr_val ? wr_data : next_cnt;
      irq_o <= hit && !wr_val;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFS_MOD: rd_data = mod_q;
      OFS_VAL: rd_data = val_q;
      OFS_CTL: rd_data[SELW:0] = {sel_q, run_q};
      default: rd_data = '0;
    endcase
  end

  // R1
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_val) |=> (val_q == $past(val_q)));

  // R7
  preset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_val |=> ((val_q == $past(wr_data)) && !irq_o));

  // R5
  irq_lands_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (val_q <= W'(1)));

  // R9
  zero_mod_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_q == '0) |=> !irq_o);

  // R6
  mod_write_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mod && !run_q && !wr_val) |=> (val_q == $past(val_q)));
endmodule

// File: tb/test_evt_timer.sv
`timescale 1ns/1ps
module test_evt_timer;
  localparam int W = 8;
  localparam int NPIN = 2;
  localparam int MASK = (1 << W) - 1;

  logic clk = 0, rst_n = 0, wr_en = 0, tick_i = 0, irq_o;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [W-1:0] wr_data = 0, rd_data;
  logic [1:0] dbl_i = 0;
  logic [NPIN-1:0] pin_i = 0;

  int checks = 0, fails = 0;
  string req = "R11";

  evt_timer #(.W(W), .NPIN(NPIN)) i_evt_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick_i(tick_i), .dbl_i(dbl_i),
    .pin_i(pin_i), .irq_o(irq_o));

  always #2 clk = ~clk;

  int unsigned m_mod, m_val;
  bit m_run, m_irq;
  int m_sel;
  logic [NPIN-1:0] hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mod = 0; m_val = 0; m_run = 0; m_sel = 0; m_irq = 0;
      hist = '{'0, '0, '0};
    end else begin
      int unsigned inc, nval;
      bit nirq;
      logic [NPIN-1:0] rise;
      rise = hist[1] & ~hist[2];
      hist.push_front(pin_i);
      void'(hist.pop_back());
      inc = 0;
      if (m_run) begin
        if (m_sel == 0) inc = 1;
        else if (m_sel == 1) inc = tick_i;
        else if (m_sel == 2) inc = dbl_i[0] + dbl_i[1];
        else if (m_sel >= 3 && m_sel < 3 + NPIN) inc = rise[m_sel-3];
      end
      nval = m_val; nirq = 0;
      if (inc > 0) begin
        if (m_val < m_mod && m_val + inc >= m_mod) begin
          nval = m_val + inc - m_mod; nirq = 1;
        end else nval = (m_val + inc) & MASK;
      end
      if (wr_en) begin
        if (wr_addr == 4'h0) m_mod = wr_data;
        if (wr_addr == 4'h4) begin nval = wr_data; nirq = 0; end
        if (wr_addr == 4'h8) begin m_run = wr_data[0]; m_sel = wr_data[4:1]; end
      end
      m_val = nval; m_irq = nirq;
    end
  end

  function automatic int unsigned exp_rd(logic [3:0] a);
    case (a)
      4'h0: return m_mod;
      4'h4: return m_val;
      4'h8: return (m_sel << 1) | m_run;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    #1.5;
    if (rst_n || req == "R11") begin
      checks++;
      if (irq_o !== m_irq) begin
        fails++;
        $display("FAIL %s irq_o actual %0b expected %0b at %0t", req, irq_o, m_irq, $time);
      end
      checks++;
      if (rd_data !== W'(exp_rd(rd_addr))) begin
        fails++;
        $display("FAIL %s rd_data@%h actual %0d expected %0d at %0t", req, rd_addr, rd_data, exp_rd(rd_addr), $time);
      end
    end
  end

  task automatic step();
    logic [1:0] pick;
    @(negedge clk);
    pick = 2'($urandom_range(0, 3));
    rd_addr = {pick, 2'b00};
    tick_i = 1'($urandom);
    dbl_i = 2'($urandom);
    wr_en = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [3:0] a, int unsigned d);
    step();
    wr_en = 1; wr_addr = a; wr_data = W'(d);
  endtask

  task automatic pin_run(int idx, int n);
    for (int i = 0; i < n; i++) begin
      step();
      if ($urandom_range(0, 3) == 0) pin_i[idx] = ~pin_i[idx];
      if ($urandom_range(0, 5) == 0) pin_i[1-idx] = ~pin_i[1-idx];
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    run(2);
    rst_n = 1;
    req = "R11"; run(3);
    req = "R10"; wr(4'h0, 5); wr(4'h8, 1); wr(4'hC, 77);
    req = "R4"; run(25);
    req = "R1"; wr(4'h8, 0); run(8);
    req = "R2"; wr(4'h8, (1 << 1) | 1); run(30);
    wr(4'h8, (7 << 1) | 1); run(10);
    req = "R4"; wr(4'h8, (2 << 1) | 1); run(40);
    wr(4'h0, 4); run(40);
    req = "R3"; wr(4'h0, 3); wr(4'h8, (3 << 1) | 1); pin_run(0, 80);
    wr(4'h8, (4 << 1) | 1); pin_run(1, 80);
    req = "R6"; wr(4'h8, 1); wr(4'h0, 200); run(20); wr(4'h8, 0); wr(4'h0, 9); run(3);
    req = "R8"; wr(4'h0, 50); wr(4'h4, 120); wr(4'h8, 1); run(250);
    req = "R7"; wr(4'h0, 30); wr(4'h4, 30); run(5);
    wr(4'h8, (2 << 1) | 1); wr(4'h4, 29); run(5);
    wr(4'h8, 1); wr(4'h0, 3);
    for (int i = 0; i < 30; i++) begin
      if ($urandom_range(0, 2) == 0) wr(4'h4, $urandom_range(0, 3)); else step();
    end
    req = "R9"; wr(4'h0, 0); wr(4'h8, (2 << 1) | 1); run(300);
    req = "R5"; wr(4'h0, 1); wr(4'h4, 0); wr(4'h8, 1); run(10);
    req = "R10"; wr(4'hC, 3); run(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule